// File: doc/BRIEF.md
# Configurable Parallel-to-Serial Transmit Serializer

This block turns a parallel word from a slow core clock domain into one serial bit stream at the bit-clock rate. The number of bits per word, `FACTOR`, is fixed when the block is built. For factors 4, 6, 7, 8 and 10 each word goes into a holding register and then into a shift register. A load strobe that repeats every `FACTOR` bit-clock cycles moves the word from one to the other. For factor 2 the shifter is bypassed: a pair of output registers sends the high bit and then the low bit. For factor 1 a plain registered path sends `par_in[0]` on every bit-clock cycle.

The core clock must run at the bit-clock rate divided by `FACTOR`, and both clocks must come from the same source. The block samples `core_clk` on the bit clock and detects each rising edge. It captures the parallel word one bit-clock cycle after it sees that edge. It then realigns its strobe counter to that edge, so the word boundaries follow the core clock whatever the phase of the first edge after reset.

Top module: `ser_tx`

## Requirements
- R1: `FACTOR` takes one of 1, 2, 4, 6, 7, 8 or 10. Factors 4 and up use the shift register, factor 2 uses the paired bypass registers, and factor 1 uses the single-bit bypass.
- R2: Each word leaves most-significant bit first: bit `FACTOR-1` comes first and bit 0 comes last.
- R3: Let a word be presented with a rising `core_clk`, and let edge t be the first bit-clock edge that samples `core_clk` high. Then bit `FACTOR-1-k` of that word is on `ser_out` from bit-clock edge t+3+k, for k = 0 to `FACTOR-1`.
- R4: For factors 2 and up, the word is captured at edge t+1, one cycle after the rising edge is seen. `par_in` must stay stable from edge t through edge t+1.
- R5: The load strobe is high on the cycle that follows each capture. With a steady core clock it is high for exactly one cycle in every `FACTOR`.
- R6: Consecutive words run back to back: bit 0 of one word is followed at once by the first bit of the next word, with no idle bit.
- R7: Bits of `par_in` at index `FACTOR` and above have no effect on `ser_out`.
- R8: Reset is synchronous and active high. `ser_out` is 0 after every bit-clock edge at which `rst` is high.
- R9: In factor 2, `par_in[1]` is sent on the first bit-clock cycle of a core period and `par_in[0]` on the second.
- R10: In factor 1, `core_clk` is ignored. A value driven on `par_in[0]` before edge t appears on `ser_out` from edge t+3.
- R11: The word alignment follows `core_clk`. After reset, the first rising core edge sets the word boundary at any phase relative to the internal counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast clock at the serial bit rate; every register in the block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| core_clk | input | 1 | Slow clock from the same source; its rising edge marks a new word |
| par_in | input | IN_W (10) | Parallel word; only bits `FACTOR-1:0` are used |
| ser_out | output | 1 | Registered serial output, MSB first |

## Verification
A wrong strobe phase or a stale holding register moves or mixes bits within a word. This shows on `ser_out` within the first word after the fault, three to `FACTOR+3` bit-clock edges after the core edge. The reference model takes each word as it is driven and computes the exact edge of every serial bit from R3. It compares `ser_out` on every bit-clock cycle, so one bit that is misplaced, dropped or repeated fails on the cycle it happens. All seven factors run at the same time with random data in the unused upper bits. Each run is repeated after a reset in the middle of traffic, with a different start phase.

// File: rtl/ser_tx_pkg.sv
`timescale 1ns/1ps
package ser_tx_pkg;
  localparam int SER_MAX_W = 10;

  typedef enum logic [1:0] {
    MODE_SDR,
    MODE_DDR,
    MODE_SHIFT
  } ser_mode_e;

  function automatic ser_mode_e mode_of(input int factor);
    if (factor == 1) return MODE_SDR;
    if (factor == 2) return MODE_DDR;
    return MODE_SHIFT;
  endfunction
endpackage

// File: rtl/ser_tx_phase.sv
module ser_tx_phase #(
  parameter int FACTOR = 10,
  localparam int PW = (FACTOR > 1) ? $clog2(FACTOR) : 1
) (
  input  logic bit_clk,
  input  logic rst,
  input  logic core_clk,
  output logic cap_en,
  output logic load_en
);
  localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);

  logic          core_q;
  logic          core_q2;
  logic [PW-1:0] phase_q;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      core_q  <= 1'b0;
      core_q2 <= 1'b0;
    end else begin
      core_q  <= core_clk;
      core_q2 <= core_q;
    end
  end

  assign cap_en = core_q & ~core_q2;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (cap_en) begin
      phase_q <= LAST;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign load_en = (phase_q == LAST);
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int W = 10
) (
  input  logic         bit_clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         load_en,
  input  logic [W-1:0] word_in,
  output logic         bit_nxt,
  output logic         hold_msb
);
  logic [W-1:0] hold_q;
  logic [W-1:0] shf_q;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      hold_q <= '0;
      shf_q  <= '0;
    end else begin
      if (cap_en) hold_q <= word_in;
      if (load_en) shf_q <= hold_q;
      else         shf_q <= {shf_q[W-2:0], 1'b0};
    end
  end

  assign bit_nxt  = shf_q[W-1];
  assign hold_msb = hold_q[W-1];
endmodule

// File: rtl/ser_tx_ddr.sv
module ser_tx_ddr (
  input  logic       bit_clk,
  input  logic       rst,
  input  logic       cap_en,
  input  logic       load_en,
  input  logic [1:0] word_in,
  output logic       bit_nxt,
  output logic       hold_msb
);
  logic [1:0] hold_q;
  logic       hi_q;
  logic       lo_q;
  logic       hi_sel_q;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      hold_q   <= '0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
      hi_sel_q <= 1'b0;
    end else begin
      if (cap_en) hold_q <= word_in;
      if (load_en) begin
        hi_q <= hold_q[1];
        lo_q <= hold_q[0];
      end
      hi_sel_q <= load_en;
    end
  end

  assign bit_nxt  = hi_sel_q ? hi_q : lo_q;
  assign hold_msb = hold_q[1];
endmodule

// File: rtl/ser_tx_sdr.sv
module ser_tx_sdr #(
  parameter int STAGES = 3
) (
  input  logic bit_clk,
  input  logic rst,
  input  logic bit_in,
  output logic bit_nxt
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge bit_clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge bit_clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], bit_in};
      end
    end
  endgenerate

  assign bit_nxt = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int FACTOR = 10,
  parameter int IN_W   = SER_MAX_W
) (
  input  logic            bit_clk,
  input  logic            rst,
  input  logic            core_clk,
  input  logic [IN_W-1:0] par_in,
  output logic            ser_out
);
  localparam ser_mode_e MODE = mode_of(FACTOR);

  logic cap_en;
  logic load_en;
  logic bit_nxt;
  logic hold_msb;

  generate
    if (MODE == MODE_SDR) begin : g_sdr
      assign cap_en   = 1'b0;
      assign load_en  = 1'b0;
      assign hold_msb = 1'b0;
      ser_tx_sdr #(.STAGES(3)) sdr_i (
        .bit_clk (bit_clk),
        .rst     (rst),
        .bit_in  (par_in[0]),
        .bit_nxt (bit_nxt)
      );
    end else begin : g_timed
      ser_tx_phase #(.FACTOR(FACTOR)) phase_i (
        .bit_clk  (bit_clk),
        .rst      (rst),
        .core_clk (core_clk),
        .cap_en   (cap_en),
        .load_en  (load_en)
      );
      if (MODE == MODE_DDR) begin : g_ddr
        ser_tx_ddr ddr_i (
          .bit_clk  (bit_clk),
          .rst      (rst),
          .cap_en   (cap_en),
          .load_en  (load_en),
          .word_in  (par_in[1:0]),
          .bit_nxt  (bit_nxt),
          .hold_msb (hold_msb)
        );
      end else begin : g_shift
        ser_tx_shift #(.W(FACTOR)) shift_i (
          .bit_clk  (bit_clk),
          .rst      (rst),
          .cap_en   (cap_en),
          .load_en  (load_en),
          .word_in  (par_in[FACTOR-1:0]),
          .bit_nxt  (bit_nxt),
          .hold_msb (hold_msb)
        );
      end
    end
  endgenerate

  always_ff @(posedge bit_clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= bit_nxt;
  end

  logic unused_sig;
  assign unused_sig = ^{par_in, core_clk, cap_en, load_en, hold_msb};
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int FACTOR = 10
) (
  input logic bit_clk,
  input logic rst,
  input logic cap_en,
  input logic load_en,
  input logic hold_msb,
  input logic ser_out
);
  AST_RST_QUIET: assert property (@(posedge bit_clk) rst |=> !ser_out); // R8

  generate
    if (FACTOR > 1) begin : g_timed
      AST_LOAD_AFTER_CAP: assert property (@(posedge bit_clk) disable iff (rst)
        cap_en |=> load_en); // R5
      AST_CAP_PULSE: assert property (@(posedge bit_clk) disable iff (rst)
        cap_en |=> !cap_en); // R4
      AST_MSB_FIRST: assert property (@(posedge bit_clk) disable iff (rst)
        load_en |=> ##1 (ser_out == $past(hold_msb, 2))); // R2
    end
  endgenerate
endmodule

bind ser_tx ser_tx_chk #(.FACTOR(FACTOR)) chk_i (
  .bit_clk  (bit_clk),
  .rst      (rst),
  .cap_en   (cap_en),
  .load_en  (load_en),
  .hold_msb (hold_msb),
  .ser_out  (ser_out)
);

// File: tb/ser_tx_tb_top.sv
`timescale 1ns/1ps
module ser_tx_tb_top;
  localparam int NF = 7;
  localparam int FLIST [NF] = '{1, 2, 4, 6, 7, 8, 10};  // R1: every legal factor
  localparam int SEG_CYC = 700;
  localparam int WDOG_CYC = 200000;

  logic bclk = 1'b0;
  always #2.5 bclk = ~bclk;  // 200 MHz

  logic rst = 1'b1;
  int cyc = 0;
  always @(posedge bclk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int seg = 0;

  task automatic chk(input logic got, input logic exp, input string tag, input int n);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s N=%0d cyc=%0d got=%b exp=%b", tag, n, cyc, got, exp);
    end
  endtask

  for (genvar g = 0; g < NF; g++) begin : g_f
    localparam int N = FLIST[g];
    logic cclk = 1'b0;
    logic [9:0] din = '0;
    logic dout;
    bit exp_at [int];

    ser_tx #(.FACTOR(N)) dut_i (
      .bit_clk  (bclk),
      .rst      (rst),
      .core_clk (cclk),
      .par_in   (din),
      .ser_out  (dout)
    );

    initial begin
      int j;
      int start;
      int k;
      string tag;
      j = 0;
      forever begin
        @(negedge bclk);
        if (N == 1)      tag = "R10";
        else if (N == 2) tag = "R9/R3";
        else             tag = "R2/R3/R6";
        if (seg > 0) tag = {tag, "/R11"};
        if (rst) begin
          exp_at.delete();
          j = 0;
          cclk = 1'b0;
          if (cyc >= 1) chk(dout, 1'b0, "R8", N);  // output low under reset
        end else begin
          // compare against the model: bit placement from R3, MSB first (R2),
          // no gap between words (R6, R5), capture timing (R4)
          if (exp_at.exists(cyc)) begin
            chk(dout, exp_at[cyc], tag, N);
            exp_at.delete(cyc);
          end
          start = 2 + g + 3 * seg;  // R11: varied start phase per factor and segment
          if (j >= start) begin
            k = j - start;
            if (N == 1) begin
              din = 10'($urandom);  // R7: upper bits random
              exp_at[cyc + 4] = din[0];
            end else begin
              cclk = ((k % N) < ((N + 1) / 2));
              if ((k % N) == 0) begin
                din = 10'($urandom);  // R7: bits above N-1 are random noise
                for (int b = 0; b < N; b++) exp_at[cyc + 4 + b] = din[N - 1 - b];
              end
            end
          end
          j++;
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge bclk);
    #1 rst = 1'b0;
    repeat (SEG_CYC) @(negedge bclk);
    #1 rst = 1'b1;
    repeat (4) @(negedge bclk);
    #1 begin
      seg = 1;
      rst = 1'b0;
    end
    repeat (SEG_CYC) @(negedge bclk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge bclk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired at cyc=%0d got=hung exp=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule